// File: doc/BRIEF.md
# PCI Function Power-State and Wake Controller

This block holds the power state of a single PCI function and gates that function's resources to match. Software reaches it through a small two-register write/read port. The control/status register carries the power-state field, a wake enable and a sticky wake status. The configuration register carries a local-bus clock request and, for each watched I/O pin, an arm bit and an edge-select bit. Only D0, D2 and D3 are supported. In D2 or D3 the block switches off the local-bus clock enable, the function's interrupt enable and the acceptance of I/O and memory BAR accesses. Configuration-space accesses are accepted in every state.

Wake events come from general-purpose I/O pins. Each pin first passes through a synchronizer. An armed pin that shows its programmed edge raises a wake event. If wake is enabled, the event latches the sticky status, and the status drives the active-low wake pin low until software writes a 1 to clear it. The status has its own reset input, so it survives a function reset.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After both resets, the state is D0 (code 00), the wake enable is 0, the configuration register reads 0, the wake pin is high and the clock enable is low.
- R2: A write to the control/status register (reg_sel=0) loads bits 1:0 as the state when the code is 00 (D0), 10 (D2) or 11 (D3), and bit 8 as the wake enable. Code 01 (D1) leaves the state unchanged. The new value reads back after one clock.
- R3: lclk_en is high only when the clock request (configuration bit 0) is set and the state is D0.
- R4: Outside D0, irq_en is low and bar_accept stays low even when bar_hit is high. In D0, irq_en is high and bar_accept follows bar_hit.
- R5: cfg_accept follows cfg_hit in every power state.
- R6: Pin i is armed by configuration bit 4+i. Bit 8+i selects its edge: 1 for rising, 0 for falling. Only the selected edge on an armed pin is a wake event. The opposite edge and any edge on an unarmed pin are ignored.
- R7: A wake event sets the status (bit 15) only while the wake enable (bit 8) is 1.
- R8: Writing 1 to bit 15 clears the status. Writing 0 there leaves it set.
- R9: pme_n is low exactly while the status is set.
- R10: A pin change sampled at one clock edge sets the status at the third edge from it. pme_n is still high after the first two edges and low after the third.
- R11: When a wake event and a clear of bit 15 arrive in the same cycle, the status ends set.
- R12: rst_n does not clear the status; only sticky_rst_n does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low function reset (state, enables, configuration, synchronizers) |
| sticky_rst_n | input | 1 | Active-low reset of the sticky wake status only |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control/status, 1 configuration |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mio_in | input | NUM_PINS | Asynchronous wake-source pins |
| cfg_hit | input | 1 | Configuration-space access request |
| bar_hit | input | 1 | I/O or memory BAR access request |
| lclk_en | output | 1 | Local-bus clock enable |
| irq_en | output | 1 | Function interrupt enable |
| bar_accept | output | 1 | BAR access accepted |
| cfg_accept | output | 1 | Configuration access accepted |
| pme_n | output | 1 | Active-low wake request pin |

## Verification
A corrupted state register shows up one clock after the write that caused it. It appears both in the readback and in the three gating outputs, which switch on or off together. A fault in the synchronizer or in edge detection moves the wake pin's fall away from the third edge after the pin change, or drops or invents the fall altogether, so the bench times that fall exactly. A status flop that forgets its value, clears on a zero write, loses to a simultaneous clear or follows the function reset shows at pme_n within one cycle of the offending stimulus.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

   typedef enum logic [1:0] {
      PS_D0 = 2'b00,
      PS_D1 = 2'b01,
      PS_D2 = 2'b10,
      PS_D3 = 2'b11
   } pstate_e;

   localparam int REG_W       = 16;
   localparam int STS_BIT     = 15;
   localparam int WEN_BIT     = 8;
   localparam int CLK_REQ_BIT = 0;
   localparam int ARM_LSB     = 4;
   localparam int POL_LSB     = 8;
   localparam int MAX_PINS    = 4;

   function automatic logic state_supported(input logic [1:0] code);
      return code != PS_D1;
   endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[LAST];
endmodule

// File: rtl/pwr_edge_detect.sv
module pwr_edge_detect #(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins,
   input  logic [NUM_PINS-1:0] arm,
   input  logic [NUM_PINS-1:0] rise_sel,
   output logic [NUM_PINS-1:0] pin_hit,
   output logic                wake_evt
);
   logic [NUM_PINS-1:0] synced;
   logic [NUM_PINS-1:0] prev_q;

   pwr_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins),
      .q     (synced)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= synced;
   end

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         logic rose, fell;
         assign rose       = synced[i] & ~prev_q[i];
         assign fell       = ~synced[i] & prev_q[i];
         assign pin_hit[i] = arm[i] & (rise_sel[i] ? rose : fell);
      end
   endgenerate

   assign wake_evt = |pin_hit;
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs
   import pwr_wake_pkg::*;
#(
   parameter int NUM_PINS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_sel,
   input  logic [REG_W-1:0]    reg_wdata,
   output pstate_e             state,
   output logic                wake_en,
   output logic                clk_req,
   output logic [NUM_PINS-1:0] arm,
   output logic [NUM_PINS-1:0] rise_sel
);
   logic ctrl_wr, cfg_wr;
   assign ctrl_wr = reg_wr & ~reg_sel;
   assign cfg_wr  = reg_wr &  reg_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PS_D0;
         wake_en <= 1'b0;
      end else if (ctrl_wr) begin
         if (state_supported(reg_wdata[1:0]))
            state <= pstate_e'(reg_wdata[1:0]);
         wake_en <= reg_wdata[WEN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_req  <= 1'b0;
         arm      <= '0;
         rise_sel <= '0;
      end else if (cfg_wr) begin
         clk_req  <= reg_wdata[CLK_REQ_BIT];
         arm      <= reg_wdata[ARM_LSB +: NUM_PINS];
         rise_sel <= reg_wdata[POL_LSB +: NUM_PINS];
      end
   end
endmodule

// File: rtl/pwr_wake_status.sv
module pwr_wake_status (
   input  logic clk,
   input  logic sticky_rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic sts
);
   always_ff @(posedge clk or negedge sticky_rst_n) begin
      if (!sticky_rst_n)  sts <= 1'b0;
      else if (set_req)   sts <= 1'b1;
      else if (clr_req)   sts <= 1'b0;
   end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwr_wake_pkg::*;
#(
   parameter int NUM_PINS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sticky_rst_n,
   input  logic                reg_wr,
   input  logic                reg_sel,
   input  logic [15:0]         reg_wdata,
   output logic [15:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] mio_in,
   input  logic                cfg_hit,
   input  logic                bar_hit,
   output logic                lclk_en,
   output logic                irq_en,
   output logic                bar_accept,
   output logic                cfg_accept,
   output logic                pme_n
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
         $error("pwr_wake_ctrl: NUM_PINS out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pwr_wake_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   pstate_e             state_q;
   logic                wake_en_q;
   logic                clk_req_q;
   logic [NUM_PINS-1:0] arm_q;
   logic [NUM_PINS-1:0] rise_q;
   logic [NUM_PINS-1:0] pin_hit;
   logic                wake_evt;
   logic                sts_q;
   logic                full_power;
   logic                w1c;

   pwr_regs #(.NUM_PINS(NUM_PINS)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .state     (state_q),
      .wake_en   (wake_en_q),
      .clk_req   (clk_req_q),
      .arm       (arm_q),
      .rise_sel  (rise_q)
   );

   pwr_edge_detect #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins     (mio_in),
      .arm      (arm_q),
      .rise_sel (rise_q),
      .pin_hit  (pin_hit),
      .wake_evt (wake_evt)
   );

   assign w1c = reg_wr & ~reg_sel & reg_wdata[STS_BIT];

   pwr_wake_status i_status (
      .clk          (clk),
      .sticky_rst_n (sticky_rst_n),
      .set_req      (wake_evt & wake_en_q),
      .clr_req      (w1c),
      .sts          (sts_q)
   );

   assign full_power = (state_q == PS_D0);
   assign lclk_en    = clk_req_q & full_power;
   assign irq_en     = full_power;
   assign bar_accept = bar_hit & full_power;
   assign cfg_accept = cfg_hit;
   assign pme_n      = ~sts_q;

   logic unused_hits;
   assign unused_hits = ^pin_hit;

   always_comb begin
      reg_rdata = '0;
      if (!reg_sel) begin
         reg_rdata[1:0]     = state_q;
         reg_rdata[WEN_BIT] = wake_en_q;
         reg_rdata[STS_BIT] = sts_q;
      end else begin
         reg_rdata[CLK_REQ_BIT]          = clk_req_q;
         reg_rdata[ARM_LSB +: NUM_PINS]  = arm_q;
         reg_rdata[POL_LSB +: NUM_PINS]  = rise_q;
      end
   end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sticky_rst_n,
   input logic        reg_wr,
   input logic        reg_sel,
   input logic [15:0] reg_wdata,
   input logic [1:0]  state,
   input logic        wake_en,
   input logic        wake_evt,
   input logic        sts,
   input logic        lclk_en,
   input logic        irq_en,
   input logic        bar_accept
);
   // R2
   no_d1_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'b01);

   // R2
   d1_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel && reg_wdata[1:0] == 2'b01) |=> $stable(state));

   // R3
   clk_off_low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'b00) |-> !lclk_en);

   // R4
   irq_bar_off_low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'b00) |-> (!irq_en && !bar_accept));

   // R7
   no_set_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n || !sticky_rst_n)
      (!sts && !wake_en) |=> !sts);

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!sticky_rst_n)
      (sts && !(reg_wr && !reg_sel && reg_wdata[15])) |=> sts);

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || !sticky_rst_n)
      (wake_evt && wake_en) |=> sts);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sticky_rst_n (sticky_rst_n),
   .reg_wr       (reg_wr),
   .reg_sel      (reg_sel),
   .reg_wdata    (reg_wdata),
   .state        (state_q),
   .wake_en      (wake_en_q),
   .wake_evt     (wake_evt),
   .sts          (sts_q),
   .lclk_en      (lclk_en),
   .irq_en       (irq_en),
   .bar_accept   (bar_accept)
);

// File: tb/test_pwr_wake_ctrl.sv
`timescale 1ns/1ps
module test_pwr_wake_ctrl;
   localparam int NP = 2;
   localparam int K_RD = 0, K_LCLK = 1, K_IRQ = 2, K_BAR = 3, K_CFG = 4, K_PME = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sticky_rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic [NP-1:0] mio_in = '0;
   logic          cfg_hit = 1'b0;
   logic          bar_hit = 1'b0;
   logic          lclk_en, irq_en, bar_accept, cfg_accept, pme_n;

   always #4 clk = ~clk;

   pwr_wake_ctrl #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_pwr_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .sticky_rst_n(sticky_rst_n),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mio_in(mio_in), .cfg_hit(cfg_hit), .bar_hit(bar_hit),
      .lclk_en(lclk_en), .irq_en(irq_en), .bar_accept(bar_accept),
      .cfg_accept(cfg_accept), .pme_n(pme_n)
   );

   typedef struct {
      int          kind;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   event  chk_done;

   function automatic logic [15:0] actual(input int kind);
      case (kind)
         K_RD:    return reg_rdata;
         K_LCLK:  return {15'd0, lclk_en};
         K_IRQ:   return {15'd0, irq_en};
         K_BAR:   return {15'd0, bar_accept};
         K_CFG:   return {15'd0, cfg_accept};
         default: return {15'd0, pme_n};
      endcase
   endfunction

   // monitor: pops expected items and compares shortly after each rising edge
   initial begin
      item_t it;
      logic [15:0] act;
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            it  = q.pop_front();
            act = actual(it.kind);
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
            -> chk_done;
         end
      end
   end

   task automatic expect_val(input int kind, input logic [15:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
      @(chk_done);
   endtask

   task automatic wr(input logic sel, input logic [15:0] data);
      @(negedge clk);
      reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_sel = sel;
      expect_val(K_RD, exp, tag);
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1; sticky_rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, 16'h0000, "R1 ctrl after reset");
      rd(1'b1, 16'h0000, "R1 cfg after reset");
      expect_val(K_PME,  16'd1, "R1 pme_n after reset");
      expect_val(K_LCLK, 16'd0, "R1 lclk_en after reset");

      // R3 / R4 / R5 in D0
      wr(1'b1, 16'h0001);
      expect_val(K_LCLK, 16'd1, "R3 clock on in D0 with request");
      bar_hit = 1'b1; cfg_hit = 1'b1;
      expect_val(K_IRQ, 16'd1, "R4 irq enabled in D0");
      expect_val(K_BAR, 16'd1, "R4 bar accepted in D0");
      expect_val(K_CFG, 16'd1, "R5 cfg accepted in D0");

      // R2 enter D2
      wr(1'b0, 16'h0002);
      rd(1'b0, 16'h0002, "R2 state D2");
      expect_val(K_LCLK, 16'd0, "R3 clock off in D2");
      expect_val(K_IRQ,  16'd0, "R4 irq off in D2");
      expect_val(K_BAR,  16'd0, "R4 bar blocked in D2");
      expect_val(K_CFG,  16'd1, "R5 cfg accepted in D2");

      // R2 D1 request ignored
      wr(1'b0, 16'h0001);
      rd(1'b0, 16'h0002, "R2 D1 write keeps D2");

      wr(1'b0, 16'h0003);
      rd(1'b0, 16'h0003, "R2 state D3");
      expect_val(K_BAR, 16'd0, "R4 bar blocked in D3");
      expect_val(K_CFG, 16'd1, "R5 cfg accepted in D3");
      wr(1'b0, 16'h0000);
      expect_val(K_LCLK, 16'd1, "R3 clock back in D0");
      bar_hit = 1'b0; cfg_hit = 1'b0;
      expect_val(K_CFG, 16'd0, "R5 cfg follows idle hit");

      // R6/R7: pin0 rising, pin1 falling, both armed
      wr(1'b1, 16'h0131);
      rd(1'b1, 16'h0131, "R6 config readback");
      @(negedge clk); mio_in[0] = 1'b1; settle();
      expect_val(K_PME, 16'd1, "R7 event ignored with wake disabled");
      wr(1'b0, 16'h0100);
      @(negedge clk); mio_in[0] = 1'b0; settle();
      expect_val(K_PME, 16'd1, "R6 opposite edge on pin0 ignored");
      @(negedge clk); mio_in[1] = 1'b1; settle();
      expect_val(K_PME, 16'd1, "R6 opposite edge on pin1 ignored");
      wr(1'b1, 16'h0121);
      @(negedge clk); mio_in[0] = 1'b1; settle();
      expect_val(K_PME, 16'd1, "R6 unarmed pin ignored");
      @(negedge clk); mio_in[0] = 1'b0; settle();
      wr(1'b1, 16'h0131);

      // R10 latency of pin0 rising edge
      @(negedge clk); mio_in[0] = 1'b1;
      expect_val(K_PME, 16'd1, "R10 pme_n high after edge 1");
      expect_val(K_PME, 16'd1, "R10 pme_n high after edge 2");
      expect_val(K_PME, 16'd0, "R10 pme_n low after edge 3");
      rd(1'b0, 16'h8100, "R9 status bit visible");

      // R8 write-0 no effect, write-1 clears
      wr(1'b0, 16'h0100);
      expect_val(K_PME, 16'd0, "R8 write 0 keeps status");
      wr(1'b0, 16'h8100);
      rd(1'b0, 16'h0100, "R8 write 1 clears status");
      expect_val(K_PME, 16'd1, "R9 pme_n released");

      // R11 set wins over simultaneous clear
      @(negedge clk); mio_in[0] = 1'b0; settle();
      @(negedge clk); mio_in[0] = 1'b1; settle();
      expect_val(K_PME, 16'd0, "R6 armed rising edge wakes");
      @(negedge clk); mio_in[1] = 1'b0;
      @(negedge clk);
      @(negedge clk); reg_sel = 1'b0; reg_wdata = 16'h8100; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      expect_val(K_PME, 16'd0, "R11 set wins over clear");
      wr(1'b0, 16'h8100);
      expect_val(K_PME, 16'd1, "R11 later clear works");

      // R12 function reset keeps status
      @(negedge clk); mio_in[0] = 1'b0; settle();
      @(negedge clk); mio_in[0] = 1'b1; settle();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      rd(1'b0, 16'h8000, "R12 status survives function reset");
      expect_val(K_PME, 16'd0, "R12 pme_n held through function reset");
      @(negedge clk); sticky_rst_n = 1'b0;
      @(negedge clk); sticky_rst_n = 1'b1;
      expect_val(K_PME, 16'd1, "R12 sticky reset clears status");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule